// File: doc/BRIEF.md
# RTC Calendar Update Engine

This block keeps the eight time and calendar bytes of a real-time clock (seconds, minutes, hours, weekday, date, month, year, century) and advances them once per second. Each byte is held in one of two encodings, picked by a mode input: packed BCD or plain binary. The hours byte is in either 24-hour or 12-hour form. Two optional daylight-saving jumps can be enabled. A prescaler outside the block supplies the once-per-second tick. An interrupt controller outside the block consumes the update-ended pulse.

Each tick opens a warning window. During it the update-in-progress flag is high for a fixed number of clocks. The eight bytes then change together in one clock edge. A hold input lets software freeze the clock while it loads new values through a byte-wide write port. Asserting the hold input also cancels an update that has been announced but not yet committed.

Top module: `rtc_calendar_engine`

## Requirements
- R1: After reset the bytes read seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01, year 00 and century 00, and both `uip` and `upd_done` are low.
- R2: A `sec_tick` that arrives with `uip` low and `set_hold` low raises `uip` in the next cycle. `uip` then stays high for UIP_LEAD cycles, with the bytes unchanged. In the next cycle all changed bytes appear together, `upd_done` is high for exactly that one cycle, and `uip` is low again. A tick that arrives while `uip` is high is ignored.
- R3: While `set_hold` is 1, ticks are ignored and no byte changes except through writes. Raising `set_hold` during the warning window clears `uip` on the next cycle and cancels that update, so no `upd_done` follows.
- R4: A write with `wr_en` high places `wr_data` into the byte picked by `wr_sel` in the next cycle. The selector codes are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 century. Writes work whether or not `set_hold` is set. A write in the cycle that commits an update wins for its own byte.
- R5: `data_bin`=0 means every byte is BCD (tens digit in bits 7:4). `data_bin`=1 means plain binary. Seconds and minutes count 0 to 59, hours 0 to 23, and each carry reaches the next field in the same update.
- R6: With `hour24`=0, bit 7 of the hours byte marks PM and bits 6:0 count 12, 1, …, 11. Going from 11:59:59 AM gives 12:00:00 PM. Going from 11:59:59 PM gives 12:00:00 AM and rolls the day.
- R7: At the midnight rollover the weekday counts 1 to 7 and wraps from 7 to 1 (1 is Sunday). The date wraps to 1 after the month's last day: 30 for months 4, 6, 9 and 11, 31 for the others, and for February 29 when the year is divisible by 4 and 28 otherwise.
- R8: Month 12 wraps to 1 and the year increments. Year 99 wraps to 00, and bits 6:0 of the century byte are then loaded with twenty in the current encoding (0x20 in BCD, 0x14 in binary). Century bit 7 keeps its previous value.
- R9: If `dst_en` is 1 at the midnight rollover into a Sunday in April dated 1 to 7, then on that day the update from 01:59:59 goes to 03:00:00.
- R10: If `dst_en` is 1 at the midnight rollover into a Sunday in October dated 25 or later, then the first update from 01:59:59 that day goes to 01:00:00. The second time 01:59:59 is reached that day, the clock goes on normally to 02:00:00.
- R11: No daylight-saving jump happens when `dst_en` was 0 at the midnight rollover, or when the day does not meet the Sunday and date condition. Writing the time registers does not arm a jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| set_hold | input | 1 | Freeze updates and cancel a pending one |
| data_bin | input | 1 | 1 binary bytes, 0 BCD bytes |
| hour24 | input | 1 | 1 24-hour format, 0 12-hour with PM in bit 7 |
| dst_en | input | 1 | Daylight-saving jumps enabled |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 3 | Byte selector for writes |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| wday_o | output | 8 | Weekday byte |
| mday_o | output | 8 | Date byte |
| mon_o | output | 8 | Month byte |
| year_o | output | 8 | Year byte |
| cent_o | output | 8 | Century byte |
| uip | output | 1 | Update-in-progress flag |
| upd_done | output | 1 | One-cycle update-ended pulse |

## Verification
Random starting times are biased toward 59 seconds, 59 minutes, 23 hours, the month's last day, December and year 99. This lets single updates reach every carry depth, under all four combinations of encoding and hour format. Directed cases cover the transitions that random values rarely land on. These are the century load with bit 7 set and clear, February in leap and common years, the AM/PM crossings, and a write that meets a commit. The daylight-saving cases arm each jump by a real midnight rollover and then place the clock at 01:59:59 by writes. They tell apart the forward jump, the one-time backward jump followed by a normal pass, and runs with the feature disabled or on a non-qualifying Sunday.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int RTC_NREG  = 8;
   localparam int RTC_SELW  = $clog2(RTC_NREG);
   localparam int RTC_BYTEW = 8;
   localparam int RTC_VALW  = 7;

   typedef enum logic [RTC_SELW-1:0] {
      FLD_SEC  = 3'd0,
      FLD_MIN  = 3'd1,
      FLD_HOUR = 3'd2,
      FLD_WDAY = 3'd3,
      FLD_MDAY = 3'd4,
      FLD_MON  = 3'd5,
      FLD_YEAR = 3'd6,
      FLD_CENT = 3'd7
   } rtc_field_e;

   // stored byte -> numeric value, per data encoding
   function automatic logic [RTC_VALW-1:0] code2val(input logic [7:0] c, input logic bin);
      if (bin) return c[6:0];
      return 7'(c[7:4]) * 7'd10 + 7'(c[3:0]);
   endfunction

   // numeric value (0..99) -> stored byte, per data encoding
   function automatic logic [7:0] val2code(input logic [RTC_VALW-1:0] v, input logic bin);
      logic [RTC_VALW-1:0] tens;
      logic [RTC_VALW-1:0] ones;
      tens = v / 7'd10;
      ones = v % 7'd10;
      if (bin) return {1'b0, v};
      return {tens[3:0], ones[3:0]};
   endfunction

   function automatic logic [RTC_VALW-1:0] month_len(input logic [RTC_VALW-1:0] mon,
                                                      input logic [RTC_VALW-1:0] yr);
      case (mon)
         7'd2:                    return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
         7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
         default:                 return 7'd31;
      endcase
   endfunction

   function automatic logic [7:0] reset_code(input int idx);
      if (idx == int'(FLD_WDAY) || idx == int'(FLD_MDAY) || idx == int'(FLD_MON)) return 8'h01;
      return 8'h00;
   endfunction

endpackage

// File: rtl/rtc_uip_seq.sv
module rtc_uip_seq #(
   parameter int UIP_LEAD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_tick,
   input  logic set_hold,
   output logic uip,
   output logic commit,
   output logic upd_done
);
   localparam int CW = $clog2(UIP_LEAD + 1);

   logic [CW-1:0] lead_cnt;

   generate
      if (UIP_LEAD < 1) begin : g_bad_lead
         $error("rtc_uip_seq: UIP_LEAD must be at least 1");
      end
   endgenerate

   assign commit = uip && !set_hold && (lead_cnt == CW'(UIP_LEAD - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uip      <= 1'b0;
         lead_cnt <= '0;
         upd_done <= 1'b0;
      end else begin
         upd_done <= commit;
         if (set_hold) begin
            uip      <= 1'b0;
            lead_cnt <= '0;
         end else if (!uip) begin
            if (sec_tick) begin
               uip      <= 1'b1;
               lead_cnt <= '0;
            end
         end else if (commit) begin
            uip      <= 1'b0;
            lead_cnt <= '0;
         end else begin
            lead_cnt <= lead_cnt + 1'b1;
         end
      end
   end

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |=> !upd_done);
   p_uip_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |-> (!uip && $past(uip)));
   p_tick_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !uip && !set_hold) |=> uip);
   p_hold_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_hold |=> (!uip && !commit));

endmodule

// File: rtl/rtc_next_time.sv
module rtc_next_time
   import rtc_cal_pkg::*;
(
   input  logic [7:0]          cur_sec,
   input  logic [7:0]          cur_min,
   input  logic [7:0]          cur_hour,
   input  logic [7:0]          cur_wday,
   input  logic [7:0]          cur_mday,
   input  logic [7:0]          cur_mon,
   input  logic [7:0]          cur_year,
   input  logic [7:0]          cur_cent,
   input  logic                data_bin,
   input  logic                hour24,
   input  logic                spring_arm,
   input  logic                fall_arm,
   output logic [7:0]          nxt_sec,
   output logic [7:0]          nxt_min,
   output logic [7:0]          nxt_hour,
   output logic [7:0]          nxt_wday,
   output logic [7:0]          nxt_mday,
   output logic [7:0]          nxt_mon,
   output logic [7:0]          nxt_year,
   output logic [7:0]          nxt_cent,
   output logic                day_roll,
   output logic                used_spring,
   output logic                used_fall,
   output logic [RTC_VALW-1:0] nb_wday,
   output logic [RTC_VALW-1:0] nb_mday,
   output logic [RTC_VALW-1:0] nb_mon
);
   logic [RTC_VALW-1:0] s, m, h, h12, wd, d, mo, y, dim;
   logic [RTC_VALW-1:0] s_n, m_n, h_n, h12_n, wd_n, d_n, mo_n, y_n;
   logic                pm, pm_n, at_159, cent_load;
   logic [7:0]          h12_code, twenty_code;

   always_comb begin
      // decode to numeric values
      s   = code2val(cur_sec, data_bin);
      m   = code2val(cur_min, data_bin);
      pm  = cur_hour[7];
      h12 = code2val({1'b0, cur_hour[6:0]}, data_bin);
      if (hour24) h = code2val(cur_hour, data_bin);
      else        h = ((h12 == 7'd12) ? 7'd0 : h12) + (pm ? 7'd12 : 7'd0);
      wd  = code2val(cur_wday, data_bin);
      d   = code2val(cur_mday, data_bin);
      mo  = code2val(cur_mon, data_bin);
      y   = code2val(cur_year, data_bin);
      dim = month_len(mo, y);

      at_159      = (h == 7'd1) && (m == 7'd59) && (s == 7'd59);
      used_spring = spring_arm && at_159;
      used_fall   = fall_arm && at_159 && !used_spring;

      // time-of-day carry chain
      s_n = s; m_n = m; h_n = h; day_roll = 1'b0;
      if (s >= 7'd59) begin
         s_n = 7'd0;
         if (m >= 7'd59) begin
            m_n = 7'd0;
            if (h >= 7'd23) begin
               h_n      = 7'd0;
               day_roll = 1'b1;
            end else begin
               h_n = h + 7'd1;
            end
         end else begin
            m_n = m + 7'd1;
         end
      end else begin
         s_n = s + 7'd1;
      end
      if (used_spring) h_n = 7'd3;
      if (used_fall)   h_n = 7'd1;

      // calendar carry chain
      wd_n = wd; d_n = d; mo_n = mo; y_n = y; cent_load = 1'b0;
      if (day_roll) begin
         wd_n = (wd >= 7'd7) ? 7'd1 : wd + 7'd1;
         if (d >= dim) begin
            d_n = 7'd1;
            if (mo >= 7'd12) begin
               mo_n = 7'd1;
               if (y >= 7'd99) begin
                  y_n       = 7'd0;
                  cent_load = 1'b1;
               end else begin
                  y_n = y + 7'd1;
               end
            end else begin
               mo_n = mo + 7'd1;
            end
         end else begin
            d_n = d + 7'd1;
         end
      end

      // encode back
      nxt_sec  = val2code(s_n, data_bin);
      nxt_min  = val2code(m_n, data_bin);
      pm_n     = (h_n >= 7'd12);
      if (h_n == 7'd0)       h12_n = 7'd12;
      else if (h_n > 7'd12)  h12_n = h_n - 7'd12;
      else                   h12_n = h_n;
      h12_code = val2code(h12_n, data_bin);
      nxt_hour = hour24 ? val2code(h_n, data_bin) : {pm_n, h12_code[6:0]};
      nxt_wday = val2code(wd_n, data_bin);
      nxt_mday = val2code(d_n, data_bin);
      nxt_mon  = val2code(mo_n, data_bin);
      nxt_year = val2code(y_n, data_bin);
      twenty_code = val2code(7'd20, data_bin);
      nxt_cent = cent_load ? {cur_cent[7], twenty_code[6:0]} : cur_cent;

      nb_wday = wd_n;
      nb_mday = d_n;
      nb_mon  = mo_n;
   end

endmodule

// File: rtl/rtc_dst_track.sv
module rtc_dst_track
   import rtc_cal_pkg::*;
#(
   parameter int SPRING_MON  = 4,
   parameter int SPRING_LAST = 7,
   parameter int FALL_MON    = 10,
   parameter int FALL_FIRST  = 25
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                commit,
   input  logic                day_roll,
   input  logic                dst_en,
   input  logic [RTC_VALW-1:0] nb_wday,
   input  logic [RTC_VALW-1:0] nb_mday,
   input  logic [RTC_VALW-1:0] nb_mon,
   input  logic                used_spring,
   input  logic                used_fall,
   output logic                spring_arm,
   output logic                fall_arm
);
   logic is_sunday, spring_day, fall_day;

   generate
      if (SPRING_MON < 1 || SPRING_MON > 12 || FALL_MON < 1 || FALL_MON > 12
          || SPRING_MON == FALL_MON) begin : g_bad_month
         $error("rtc_dst_track: jump months must be distinct and in 1..12");
      end
   endgenerate

   assign is_sunday  = (nb_wday == 7'd1);
   assign spring_day = is_sunday && (nb_mon == RTC_VALW'(SPRING_MON)) && (nb_mday <= RTC_VALW'(SPRING_LAST));
   assign fall_day   = is_sunday && (nb_mon == RTC_VALW'(FALL_MON)) && (nb_mday >= RTC_VALW'(FALL_FIRST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spring_arm <= 1'b0;
         fall_arm   <= 1'b0;
      end else if (commit) begin
         if (day_roll) begin
            spring_arm <= dst_en && spring_day;
            fall_arm   <= dst_en && fall_day;
         end else begin
            if (used_spring) spring_arm <= 1'b0;
            if (used_fall)   fall_arm   <= 1'b0;
         end
      end
   end

   p_arms_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(spring_arm && fall_arm));
   p_arm_only_midnight_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!(commit && day_roll)) |=> (!$rose(spring_arm) && !$rose(fall_arm)));
   p_fall_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && used_fall) |=> !fall_arm);

endmodule

// File: rtl/rtc_calendar_engine.sv
module rtc_calendar_engine
   import rtc_cal_pkg::*;
#(
   parameter int UIP_LEAD = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic       set_hold,
   input  logic       data_bin,
   input  logic       hour24,
   input  logic       dst_en,
   input  logic       wr_en,
   input  logic [2:0] wr_sel,
   input  logic [7:0] wr_data,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] wday_o,
   output logic [7:0] mday_o,
   output logic [7:0] mon_o,
   output logic [7:0] year_o,
   output logic [7:0] cent_o,
   output logic       uip,
   output logic       upd_done
);
   logic [RTC_BYTEW-1:0] reg_q   [RTC_NREG];
   logic [RTC_BYTEW-1:0] reg_nxt [RTC_NREG];
   logic                 commit, day_roll, used_spring, used_fall;
   logic                 spring_arm, fall_arm;
   logic [RTC_VALW-1:0]  nb_wday, nb_mday, nb_mon;

   rtc_uip_seq #(.UIP_LEAD(UIP_LEAD)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .set_hold (set_hold),
      .uip      (uip),
      .commit   (commit),
      .upd_done (upd_done)
   );

   rtc_next_time u_next (
      .cur_sec     (reg_q[FLD_SEC]),
      .cur_min     (reg_q[FLD_MIN]),
      .cur_hour    (reg_q[FLD_HOUR]),
      .cur_wday    (reg_q[FLD_WDAY]),
      .cur_mday    (reg_q[FLD_MDAY]),
      .cur_mon     (reg_q[FLD_MON]),
      .cur_year    (reg_q[FLD_YEAR]),
      .cur_cent    (reg_q[FLD_CENT]),
      .data_bin    (data_bin),
      .hour24      (hour24),
      .spring_arm  (spring_arm),
      .fall_arm    (fall_arm),
      .nxt_sec     (reg_nxt[FLD_SEC]),
      .nxt_min     (reg_nxt[FLD_MIN]),
      .nxt_hour    (reg_nxt[FLD_HOUR]),
      .nxt_wday    (reg_nxt[FLD_WDAY]),
      .nxt_mday    (reg_nxt[FLD_MDAY]),
      .nxt_mon     (reg_nxt[FLD_MON]),
      .nxt_year    (reg_nxt[FLD_YEAR]),
      .nxt_cent    (reg_nxt[FLD_CENT]),
      .day_roll    (day_roll),
      .used_spring (used_spring),
      .used_fall   (used_fall),
      .nb_wday     (nb_wday),
      .nb_mday     (nb_mday),
      .nb_mon      (nb_mon)
   );

   rtc_dst_track u_dst (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit      (commit),
      .day_roll    (day_roll),
      .dst_en      (dst_en),
      .nb_wday     (nb_wday),
      .nb_mday     (nb_mday),
      .nb_mon      (nb_mon),
      .used_spring (used_spring),
      .used_fall   (used_fall),
      .spring_arm  (spring_arm),
      .fall_arm    (fall_arm)
   );

   // byte bank: a write beats the update for its own byte
   generate
      for (genvar k = 0; k < RTC_NREG; k++) begin : g_bank
         localparam logic [RTC_BYTEW-1:0] RST_V = reset_code(k);
         always_ff @(posedge clk) begin
            if (!rst_n)                                       reg_q[k] <= RST_V;
            else if (wr_en && (wr_sel == RTC_SELW'(k)))       reg_q[k] <= wr_data;
            else if (commit)                                  reg_q[k] <= reg_nxt[k];
         end
      end
   endgenerate

   assign sec_o  = reg_q[FLD_SEC];
   assign min_o  = reg_q[FLD_MIN];
   assign hour_o = reg_q[FLD_HOUR];
   assign wday_o = reg_q[FLD_WDAY];
   assign mday_o = reg_q[FLD_MDAY];
   assign mon_o  = reg_q[FLD_MON];
   assign year_o = reg_q[FLD_YEAR];
   assign cent_o = reg_q[FLD_CENT];

   p_quiet_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !wr_en) |=> ($stable(sec_o) && $stable(hour_o) && $stable(mday_o)));
   p_hold_freezes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_hold && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(year_o)));
   p_cent_msb_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !wr_en) |=> (cent_o[7] == $past(cent_o[7])));
   p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'd0) |=> (sec_o == $past(wr_data)));

endmodule

// File: tb/rtc_calendar_engine_test.sv
module rtc_calendar_engine_test;
   localparam int LEAD = 4;

   logic       clk = 1'b0;
   logic       rst_n, sec_tick, set_hold, data_bin, hour24, dst_en, wr_en;
   logic [2:0] wr_sel;
   logic [7:0] wr_data;
   logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, cent_o;
   logic       uip, upd_done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // model state (numeric, hours 0..23)
   int ms, mm, mh, mw, md, mmo, my;
   logic [7:0] mcent;
   bit spring = 0, fall = 0;

   always #5 clk = ~clk;

   rtc_calendar_engine #(.UIP_LEAD(LEAD)) uut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .set_hold(set_hold),
      .data_bin(data_bin), .hour24(hour24), .dst_en(dst_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
      .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o),
      .year_o(year_o), .cent_o(cent_o), .uip(uip), .upd_done(upd_done)
   );

   function automatic logic [7:0] enc(int v, bit bin);
      return bin ? 8'(v) : 8'((v / 10) * 16 + (v % 10));
   endfunction

   function automatic logic [7:0] ehour(int h, bit bin, bit h24);
      int h12;
      if (h24) return enc(h, bin);
      h12 = (h % 12 == 0) ? 12 : h % 12;
      return enc(h12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
   endfunction

   function automatic int dim(int mo, int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(string req);
      chk(req, "sec",  sec_o,  enc(ms, data_bin));
      chk(req, "min",  min_o,  enc(mm, data_bin));
      chk(req, "hour", hour_o, ehour(mh, data_bin, hour24));
      chk(req, "wday", wday_o, enc(mw, data_bin));
      chk(req, "mday", mday_o, enc(md, data_bin));
      chk(req, "mon",  mon_o,  enc(mmo, data_bin));
      chk(req, "year", year_o, enc(my, data_bin));
      chk(req, "cent", cent_o, mcent);
   endtask

   // model of one update, from the requirements
   task automatic model_step();
      bit at159;
      at159 = (mh == 1 && mm == 59 && ms == 59);
      if (spring && at159) begin
         mh = 3; mm = 0; ms = 0; spring = 0;
      end else if (fall && at159) begin
         mh = 1; mm = 0; ms = 0; fall = 0;
      end else begin
         ms++;
         if (ms == 60) begin ms = 0; mm++; end
         if (mm == 60) begin mm = 0; mh++; end
         if (mh == 24) begin
            mh = 0;
            mw = (mw == 7) ? 1 : mw + 1;
            md++;
            if (md > dim(mmo, my)) begin md = 1; mmo++; end
            if (mmo > 12) begin
               mmo = 1; my++;
               if (my > 99) begin
                  my = 0;
                  mcent = {mcent[7], 7'(enc(20, data_bin))};
               end
            end
            spring = dst_en && mw == 1 && mmo == 4 && md <= 7;
            fall   = dst_en && mw == 1 && mmo == 10 && md >= 25;
         end
      end
   endtask

   task automatic wr(int sel, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_time(int h, int m, int s);
      wr(0, enc(s, data_bin)); wr(1, enc(m, data_bin)); wr(2, ehour(h, data_bin, hour24));
      ms = s; mm = m; mh = h;
   endtask

   task automatic load(int h, int m, int s, int w, int d, int mo, int y, logic [7:0] c);
      set_time(h, m, s);
      wr(3, enc(w, data_bin)); wr(4, enc(d, data_bin)); wr(5, enc(mo, data_bin));
      wr(6, enc(y, data_bin)); wr(7, c);
      mw = w; md = d; mmo = mo; my = y; mcent = c;
   endtask

   // full update: tick, lead window, commit, pulse
   task automatic step(string req);
      logic [7:0] old_sec;
      old_sec = sec_o;
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      chk("R2", "uip raised", 8'(uip), 8'd1);
      repeat (LEAD - 1) @(negedge clk);
      chk("R2", "sec held in window", sec_o, old_sec);
      @(negedge clk);
      chk("R2", "done pulse", 8'(upd_done), 8'd1);
      chk("R2", "uip dropped", 8'(uip), 8'd0);
      model_step();
      chk_all(req);
      @(negedge clk);
      chk("R2", "done one cycle", 8'(upd_done), 8'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; sec_tick = 1'b0; set_hold = 1'b0; data_bin = 1'b0;
      hour24 = 1'b1; dst_en = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      ms = 0; mm = 0; mh = 0; mw = 1; md = 1; mmo = 1; my = 0; mcent = 8'h00;
      chk_all("R1");
      chk("R1", "uip", 8'(uip), 8'd0);
      chk("R1", "done", 8'(upd_done), 8'd0);

      // R5 R8 full BCD rollover, century bit7 set
      load(23, 59, 59, 7, 31, 12, 99, 8'h99);
      step("R8");
      chk("R8", "century msb kept", cent_o, 8'hA0);
      // R5 R8 binary rollover, century bit7 clear
      data_bin = 1'b1;
      load(23, 59, 59, 3, 31, 12, 99, 8'h05);
      step("R8");
      chk("R8", "binary century", cent_o, 8'h14);
      // R7 February lengths
      data_bin = 1'b0;
      load(23, 59, 59, 2, 28, 2, 24, 8'h20); step("R7");
      chk("R7", "leap feb 29", mday_o, 8'h29);
      step_to_midnight();
      chk("R7", "march after 29", mon_o, 8'h03);
      load(23, 59, 59, 2, 28, 2, 23, 8'h20); step("R7");
      chk("R7", "common feb wraps", mday_o, 8'h01);
      load(23, 59, 59, 6, 30, 4, 23, 8'h20); step("R7");
      chk("R7", "april 30 wraps", mon_o, 8'h05);
      // R6 12-hour crossings
      hour24 = 1'b0;
      load(11, 59, 59, 4, 10, 6, 30, 8'h20); step("R6");
      chk("R6", "noon is PM 12", hour_o, 8'h92);
      load(23, 59, 59, 4, 10, 6, 30, 8'h20); step("R6");
      chk("R6", "midnight is AM 12", hour_o, 8'h12);
      step("R6");
      hour24 = 1'b1;

      // R4 write beats commit
      load(10, 20, 30, 2, 5, 5, 40, 8'h20);
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      repeat (LEAD - 1) @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h45;
      @(negedge clk); wr_en = 1'b0;
      model_step(); ms = 45;
      chk("R4", "write wins", sec_o, 8'h45);
      chk_all("R4");

      // R3 hold ignores ticks, writes still land
      set_hold = 1'b1;
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      repeat (LEAD + 2) begin
         chk("R3", "no uip under hold", 8'(uip), 8'd0);
         chk("R3", "no done under hold", 8'(upd_done), 8'd0);
         @(negedge clk);
      end
      chk_all("R3");
      wr(1, 8'h33); mm = 33;
      chk("R4", "write under hold", min_o, 8'h33);
      set_hold = 1'b0;
      // R3 hold cancels a pending update
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0; set_hold = 1'b1;
      chk("R3", "uip before abort", 8'(uip), 8'd1);
      @(negedge clk);
      chk("R3", "uip cleared by hold", 8'(uip), 8'd0);
      set_hold = 1'b0;
      repeat (LEAD + 2) begin
         chk("R3", "cancelled no done", 8'(upd_done), 8'd0);
         @(negedge clk);
      end
      chk_all("R3");

      // R9 spring jump
      dst_en = 1'b1;
      load(23, 59, 59, 7, 6, 4, 24, 8'h20); step("R9");
      set_time(1, 59, 59); step("R9");
      chk("R9", "to three", hour_o, 8'h03);
      // R10 fall jump once
      load(23, 59, 59, 7, 24, 10, 24, 8'h20); step("R10");
      set_time(1, 59, 59); step("R10");
      chk("R10", "back to one", hour_o, 8'h01);
      set_time(1, 59, 59); step("R10");
      chk("R10", "second pass normal", hour_o, 8'h02);
      // R11 disabled, and non-qualifying Sunday
      dst_en = 1'b0;
      load(23, 59, 59, 7, 6, 4, 24, 8'h20); step("R11");
      set_time(1, 59, 59); step("R11");
      chk("R11", "no jump disabled", hour_o, 8'h02);
      dst_en = 1'b1;
      load(23, 59, 59, 7, 13, 4, 24, 8'h20); step("R11");
      set_time(1, 59, 59); step("R11");
      chk("R11", "second Sunday no jump", hour_o, 8'h02);
      dst_en = 1'b0;

      // random carries across modes: R5 R6 R7 R8
      for (int i = 0; i < 300; i++) begin
         int rs, rm, rh, rw, rd, rmo, ry;
         data_bin = 1'($urandom);
         hour24   = 1'($urandom);
         rmo = ($urandom % 2) ? 12 : 1 + int'($urandom % 12);
         ry  = ($urandom % 2) ? 99 : int'($urandom % 100);
         rd  = ($urandom % 2) ? dim(rmo, ry) : 1 + int'($urandom % dim(rmo, ry));
         rh  = ($urandom % 2) ? 23 : int'($urandom % 24);
         rm  = ($urandom % 2) ? 59 : int'($urandom % 60);
         rs  = ($urandom % 2) ? 59 : int'($urandom % 60);
         rw  = 1 + int'($urandom % 7);
         load(rh, rm, rs, rw, rd, rmo, ry, 8'($urandom) & 8'h80 | enc(19, data_bin));
         step("R5");
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic step_to_midnight();
      set_time(23, 59, 59);
      step("R7");
   endtask

endmodule